// File: doc/BRIEF.md
# Power-Policy Clock-Enable Controller

This block keeps four clock-enable masks, one for each power policy, and drives a vector of clock enables taken from the mask of the policy that is currently active. Policy numbers run from 0 to 3. A lower number means a lower-power operating point, and policy 2 is the one in force after reset. A given clock uses the same bit position in all four masks. Software reaches the block through a single-cycle 32-bit register port. The read data is combinational on the address.

Software edits the masks in three steps. It halts the engine through the stop register and waits until the stop reads back as done. It rewrites the masks, and then it issues a go command naming a target policy. A synchronous go makes the target active on the next cycle. An auto-copy go models a voltage ramp of `RAMP_CYC` cycles and copies the target into the active load only when the ramp ends. In both cases the go bit reads 1 until the new policy has been applied. The enable outputs move only on the cycle the active load updates.

Top module: `pwr_policy_ctrl`

## Requirements
- R1: After reset the active policy and the last target are 2, all four masks and `clk_en` equal `MASK_INIT`, and the go, stop-pending, error and stopped indications are all 0.
- R2: Word addresses 0 to 3 read back the masks of policies 0 to 3, address 4 is the control word and address 5 is the stop word. Addresses 6 and 7 read as 0.
- R3: A write to a mask address changes that mask only while the engine is stopped (control bit 13 = 1). Otherwise the write is ignored.
- R4: Writing 1 to bit 0 of address 5 makes that bit read 1 (stop pending). The stop takes effect on the first cycle after the engine is idle, with the go bit at 0. From then on, bit 0 reads 0 and control bit 13 (stopped) reads 1.
- R5: A command is a write to address 4 with go at bit 0, plus exactly one of synchronous-select at bit 1 or auto-copy at bit 2, and the target policy in bits 5:4. A write with go at 0, or with both or neither of bits 1 and 2, has no effect and raises no error.
- R6: An accepted synchronous command makes control bit 0 read 1 for exactly one cycle. When it reads 0, the active policy equals the target.
- R7: An accepted auto-copy command makes control bit 0 read 1 for exactly `RAMP_CYC` cycles. The active policy still holds its old value during the ramp and takes the target when the ramp ends.
- R8: `clk_en` equals the mask of the target policy as captured on the cycle the active load updates. It does not change on any other cycle, including mask writes made while stopped.
- R9: A well-formed command written while go reads 1 or while a stop is pending is ignored. It sets the error flag (control bit 12), which stays set until reset.
- R10: Control bits 9:8 and the `policy_idx` output report the active policy. Control bits 5:4 report the target of the last accepted command.
- R11: An accepted command restarts a stopped engine, so control bit 13 reads 0 from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 3 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| policy_idx | output | 2 | Active policy number |
| clk_en | output | NCLK | Clock enables of the active policy |

## Verification
The hardest situation to reach from the ports is a stop request and a second go that both land inside an auto-copy ramp. Both must be held off until the ramp ends. The stop must then take effect one cycle after the engine goes idle, and the error flag must be raised without disturbing the running command. The stimulus starts a ramp and writes a conflicting go and a stop on the next two cycles. It then polls go and the stop bit cycle by cycle. A seeded random loop around this case also rewrites the masks and attempts mask writes while the engine is running, so locked writes and mode changes meet in many orders.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int unsigned POLICIES = 4;
  localparam int unsigned ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] A_STOP = 3'd5;

  typedef logic [1:0] policy_t;
  localparam policy_t POLICY_RST = 2'd2;

  typedef struct packed {
    logic    go;
    logic    sync;
    logic    acopy;
    policy_t tgt;
  } cmd_t;

  // control word layout: go 0, sync 1, auto-copy 2, target 5:4,
  // active 9:8, error 12, stopped 13
  function automatic cmd_t decode_cmd(input logic [31:0] w);
    cmd_t c;
    c.go    = w[0];
    c.sync  = w[1];
    c.acopy = w[2];
    c.tgt   = w[5:4];
    return c;
  endfunction

  function automatic logic cmd_valid(input cmd_t c);
    return c.go && (c.sync ^ c.acopy);
  endfunction

  function automatic logic [31:0] pack_ctrl(input logic busy, input policy_t tgt,
                                            input policy_t act, input logic err,
                                            input logic stopped);
    logic [31:0] w;
    w        = '0;
    w[0]     = busy;
    w[5:4]   = tgt;
    w[9:8]   = act;
    w[12]    = err;
    w[13]    = stopped;
    return w;
  endfunction
endpackage

// File: rtl/ppc_engine.sv
module ppc_engine
  import ppc_pkg::*;
#(
  parameter int unsigned RAMP_CYC = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ctrl_wr,
  input  cmd_t    cmd,
  input  logic    stop_wr,
  input  logic    stop_bit,
  output logic    busy,
  output logic    stop_pend,
  output logic    stopped,
  output logic    err,
  output policy_t active,
  output policy_t tgt,
  output logic    apply,
  output logic    accept
);
  localparam int unsigned CNT_W = $clog2(RAMP_CYC + 1);
  localparam logic [CNT_W-1:0] RAMP_LD = CNT_W'(RAMP_CYC);

  logic [CNT_W-1:0] cnt;
  logic go_try, blocked, reject, stop_take;

  assign go_try    = ctrl_wr && cmd_valid(cmd);
  assign blocked   = busy || stop_pend;
  assign accept    = go_try && !blocked;
  assign reject    = go_try && blocked;
  assign apply     = busy && (cnt == CNT_W'(1));
  assign stop_take = stop_pend && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      tgt       <= POLICY_RST;
      active    <= POLICY_RST;
      err       <= 1'b0;
      stopped   <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      if (accept) begin
        busy    <= 1'b1;
        cnt     <= cmd.sync ? CNT_W'(1) : RAMP_LD;
        tgt     <= cmd.tgt;
        stopped <= 1'b0;
      end else if (apply) begin
        busy   <= 1'b0;
        cnt    <= '0;
        active <= tgt;
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
      end
      if (reject) err <= 1'b1;
      if (stop_take) begin
        stop_pend <= 1'b0;
        stopped   <= 1'b1;
      end else if (stop_wr && stop_bit && !stopped) begin
        stop_pend <= 1'b1;
      end
    end
  end

  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd.sync |=> apply); // R6
  AST_RAMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt >= CNT_W'(1)) && (cnt <= RAMP_LD)); // R7
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
  AST_STOP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> $past(!busy)); // R4
  AST_ACTIVE_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(active)); // R10
  AST_GO_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !stopped); // R11
endmodule

// File: rtl/ppc_mask_bank.sv
module ppc_mask_bank
  import ppc_pkg::*;
#(
  parameter int unsigned NCLK = 32,
  parameter logic [NCLK-1:0] MASK_INIT = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  policy_t         widx,
  input  logic [NCLK-1:0] wdata,
  input  logic            unlocked,
  input  policy_t         rd_idx,
  input  logic            apply,
  input  policy_t         apply_idx,
  output logic [NCLK-1:0] rd_mask,
  output logic [NCLK-1:0] clk_en
);
  logic [NCLK-1:0] mask_q [POLICIES];
  logic [POLICIES*NCLK-1:0] mask_flat;

  for (genvar p = 0; p < POLICIES; p++) begin : g_pol
    logic [NCLK-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 q <= MASK_INIT;
      else if (wr && unlocked && widx == policy_t'(p)) q <= wdata;
    end
    assign mask_q[p] = q;
  end

  always_comb begin
    for (int p = 0; p < POLICIES; p++) mask_flat[p*NCLK +: NCLK] = mask_q[p];
  end

  assign rd_mask = mask_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     clk_en <= MASK_INIT;
    else if (apply) clk_en <= mask_q[apply_idx];
  end

  AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !unlocked |=> $stable(mask_flat)); // R3
  AST_CLKEN_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(clk_en)); // R8
endmodule

// File: rtl/pwr_policy_ctrl.sv
module pwr_policy_ctrl
  import ppc_pkg::*;
#(
  parameter int unsigned NCLK      = 32,
  parameter int unsigned RAMP_CYC  = 8,
  parameter logic [NCLK-1:0] MASK_INIT = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic [1:0]      policy_idx,
  output logic [NCLK-1:0] clk_en
);
  cmd_t    cmd;
  logic    ctrl_wr, stop_wr, mask_wr;
  logic    busy, stop_pend, stopped, err, apply, accept;
  policy_t active, tgt;
  logic [NCLK-1:0] rd_mask;

  assign cmd     = decode_cmd(reg_wdata);
  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign stop_wr = reg_wr && (reg_addr == A_STOP);
  assign mask_wr = reg_wr && !reg_addr[2];

  ppc_engine #(.RAMP_CYC(RAMP_CYC)) u_engine (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .cmd(cmd),
    .stop_wr(stop_wr), .stop_bit(reg_wdata[0]),
    .busy(busy), .stop_pend(stop_pend), .stopped(stopped), .err(err),
    .active(active), .tgt(tgt), .apply(apply), .accept(accept)
  );

  ppc_mask_bank #(.NCLK(NCLK), .MASK_INIT(MASK_INIT)) u_masks (
    .clk(clk), .rst_n(rst_n), .wr(mask_wr), .widx(reg_addr[1:0]),
    .wdata(reg_wdata[NCLK-1:0]), .unlocked(stopped),
    .rd_idx(reg_addr[1:0]), .apply(apply), .apply_idx(tgt),
    .rd_mask(rd_mask), .clk_en(clk_en)
  );

  always_comb begin
    case (reg_addr)
      3'd0, 3'd1, 3'd2, 3'd3: reg_rdata = 32'(rd_mask);
      A_CTRL:                 reg_rdata = pack_ctrl(busy, tgt, active, err, stopped);
      A_STOP:                 reg_rdata = {31'b0, stop_pend};
      default:                reg_rdata = '0;
    endcase
  end

  assign policy_idx = active;

  AST_NO_APPLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> busy && !accept); // R7
endmodule

// File: tb/pwr_policy_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_policy_ctrl_tb;
  localparam int NCLK = 32;
  localparam int RAMP = 8;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0]  policy_idx;
  logic [NCLK-1:0] clk_en;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] m [4];
  logic [1:0]  e_act, e_tgt;
  logic        e_err, e_stopped;
  logic [31:0] e_clk;

  always #2.5 clk = ~clk;

  pwr_policy_ctrl #(.NCLK(NCLK), .RAMP_CYC(RAMP)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .policy_idx(policy_idx), .clk_en(clk_en)
  );

  function automatic logic [31:0] exp_ctrl(input logic go);
    return {18'b0, e_stopped, e_err, 2'b0, e_act, 2'b0, e_tgt, 3'b0, go};
  endfunction

  function automatic logic [31:0] mk_cmd(input bit sync, input logic [1:0] t);
    return {26'b0, t, 1'b0, !sync, sync, 1'b1};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic stop_engine();
    logic [31:0] d;
    wr(3'd5, 32'h1);
    rd(3'd5, d); check("R4 stop pending", d, 32'h1);
    @(negedge clk);
    rd(3'd5, d); check("R4 stop done", d, 32'h0);
    e_stopped = 1'b1;
    rd(3'd4, d); check("R4 stopped bit", d, exp_ctrl(1'b0));
  endtask

  task automatic run_go(input bit sync, input logic [1:0] t);
    logic [31:0] d;
    int n;
    wr(3'd4, mk_cmd(sync, t));
    e_tgt = t; e_stopped = 1'b0;
    n = 0;
    rd(3'd4, d);
    while (d[0] && n < RAMP + 4) begin
      check(sync ? "R6 hold" : "R7 hold", {30'b0, policy_idx}, {30'b0, e_act});
      check("R8 clk_en held", clk_en, e_clk);
      @(negedge clk); n++;
      rd(3'd4, d);
    end
    check(sync ? "R6 go length" : "R7 go length", n, sync ? 1 : RAMP);
    e_act = t; e_clk = m[t];
    check("R10 policy_idx", {30'b0, policy_idx}, {30'b0, t});
    check("R8 clk_en applied", clk_en, e_clk);
    check("R10 R11 ctrl", d, exp_ctrl(1'b0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, old;
    logic [1:0]  t;
    int unused_seed;
    unused_seed = $urandom(32'h5eed1);
    for (int i = 0; i < 4; i++) m[i] = '1;
    e_act = 2'd2; e_tgt = 2'd2; e_err = 1'b0; e_stopped = 1'b0; e_clk = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 policy_idx", {30'b0, policy_idx}, 32'd2);
    check("R1 clk_en", clk_en, 32'hffff_ffff);
    rd(3'd4, d); check("R1 ctrl", d, exp_ctrl(1'b0));
    rd(3'd5, d); check("R1 stop", d, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), d); check("R1 R2 mask", d, 32'hffff_ffff);
    end
    rd(3'd6, d); check("R2 unused 6", d, 32'h0);
    rd(3'd7, d); check("R2 unused 7", d, 32'h0);

    // R3 write while running is ignored
    wr(3'd1, 32'h1234_5678);
    rd(3'd1, d); check("R3 locked", d, 32'hffff_ffff);

    // R5 malformed commands
    wr(3'd4, 32'h0000_0017);
    wr(3'd4, 32'h0000_0011);
    wr(3'd4, 32'h0000_0012);
    rd(3'd4, d); check("R5 malformed ignored", d, exp_ctrl(1'b0));
    check("R5 policy unchanged", {30'b0, policy_idx}, 32'd2);

    // directed: stop, edit, sync then async
    stop_engine();
    for (int i = 0; i < 4; i++) begin
      m[i] = 32'h0101_0101 << i;
      wr(3'(i), m[i]);
      rd(3'(i), d); check("R2 R3 mask write", d, m[i]);
    end
    check("R8 clk_en ignores edits", clk_en, e_clk);
    run_go(1'b1, 2'd0);
    run_go(1'b0, 2'd3);

    // directed: conflicting go and stop inside a ramp
    wr(3'd4, mk_cmd(1'b0, 2'd1));
    e_tgt = 2'd1;
    wr(3'd4, mk_cmd(1'b1, 2'd2));
    e_err = 1'b1;
    wr(3'd5, 32'h1);
    rd(3'd5, d); check("R4 stop waits", d, 32'h1);
    rd(3'd4, d); check("R9 err during ramp", d, exp_ctrl(1'b1));
    while (d[0]) begin @(negedge clk); rd(3'd4, d); end
    e_act = 2'd1; e_clk = m[1];
    rd(3'd5, d); check("R4 pending at idle", d, 32'h1);
    check("R9 first command kept", {30'b0, policy_idx}, 32'd1);
    check("R8 clk_en after ramp", clk_en, e_clk);
    @(negedge clk);
    e_stopped = 1'b1;
    rd(3'd5, d); check("R4 stop after idle", d, 32'h0);
    rd(3'd4, d); check("R9 R4 ctrl", d, exp_ctrl(1'b0));

    // random rounds
    for (int r = 0; r < 24; r++) begin
      if (!e_stopped) begin
        if ($urandom_range(0, 1)) begin
          t = 2'($urandom_range(0, 3));
          wr(3'(t), $urandom);
          rd(3'(t), d); check("R3 locked random", d, m[t]);
        end
        stop_engine();
      end
      for (int k = 0; k < 4; k++) begin
        if ($urandom_range(0, 2) != 0) begin
          m[k] = $urandom;
          wr(3'(k), m[k]);
        end
        rd(3'(k), d); check("R2 readback", d, m[k]);
      end
      check("R8 clk_en while stopped", clk_en, e_clk);
      run_go($urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)));
    end

    // R9 error stays set
    rd(3'd4, d); check("R9 sticky", d[12], 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule